// File: doc/BRIEF.md
# Parallel Wide Magnitude Comparator

This block compares two unsigned 24-bit operands and reports, on three outputs, whether the first is equal to, greater than or less than the second. It is purely combinational. Each output settles one combinational delay after the operands change, and nothing in it is registered.

The operands are cut into three byte-wide slices. Each slice works out, on its own, whether its two bytes match and whether the byte from the first operand is larger. A single merge stage then looks at all three slices at the same moment. A byte can decide the result only when every more significant byte matches. Because the slice results are joined in one sum-of-products level instead of being handed from slice to slice, the delay does not grow with each extra slice. The less-than output is derived from the other two: it is high when the operands are neither equal nor ordered first-over-second.

Top module: `wide_mag_cmp`

## Requirements
- R1: `equal_o` is high exactly when all 24 bits of `opd_a_i` match `opd_b_i`.
- R2: When the most significant bytes (bits 23:16) differ, `greater_o` is high exactly when the byte of `opd_a_i` is larger, whatever the lower 16 bits hold.
- R3: When bits 23:16 match and bits 15:8 differ, the middle byte alone decides `greater_o`, whatever bits 7:0 hold.
- R4: When bits 23:8 match, the least significant byte (bits 7:0) alone decides `greater_o`.
- R5: `less_o` is high exactly when `opd_a_i` is numerically smaller than `opd_b_i`.
- R6: For every pair of operands, exactly one of `equal_o`, `greater_o` and `less_o` is high, and inside every slice the byte-equal and byte-greater flags are never both high.
- R7: Both operands are treated as unsigned. A set bit 23 means a large value, not a negative one, so 0x800000 compares greater than 0x7FFFFF.
- R8: `greater_o` is high exactly when `opd_a_i` is numerically larger than `opd_b_i`, for any operand pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a_i | input | 24 | First unsigned operand |
| opd_b_i | input | 24 | Second unsigned operand |
| equal_o | output | 1 | High when the operands are equal |
| greater_o | output | 1 | High when the first operand is larger |
| less_o | output | 1 | High when the first operand is smaller |

## Verification
The immediate assertions inside the slice, merge and top modules take for granted that both operands carry known 0/1 values and that they are read only after the combinational paths have settled. An X or a mid-change glitch would make the output checks meaningless. The bench always drives every bit of both operands with a defined value from a task. It then holds the pair steady for several nanoseconds before it samples, and it never changes an operand while a check is pending.

// File: rtl/cmp_pkg.sv
// Package: cmp_pkg
// Holds the types shared by the slice comparators and the merge stage.
// Assumes the slice flags travel as one packed pair for each slice.
package cmp_pkg;

    // Result of comparing one slice of the two operands.
    typedef struct packed {
        logic eq;   // the slice bytes are identical
        logic gt;   // the slice byte of operand A is larger
    } slice_flags_t;

endpackage

// File: rtl/cmp_slice.sv
// Module: cmp_slice
// Compares one SLICE_W-bit piece of two unsigned operands and returns an
// equal flag and an A-greater flag. It is purely combinational.
// Assumes the inputs are unsigned and hold known values.
module cmp_slice
    import cmp_pkg::*;
#(
    parameter int SLICE_W = 8
) (
    input  logic [SLICE_W-1:0] a_i,
    input  logic [SLICE_W-1:0] b_i,
    output slice_flags_t       flags_o
);

    logic [SLICE_W-1:0] same_bit;
    logic               gt_acc;

    // Mark the bit positions where the two bytes agree.
    always_comb begin : bit_match
        same_bit = ~(a_i ^ b_i);
    end

    // Greater-than as a sum of products: bit i decides when every higher bit matches.
    always_comb begin : slice_gt
        gt_acc = 1'b0;
        for (int i = 0; i < SLICE_W; i++) begin
            logic upper_same;
            upper_same = 1'b1;
            for (int j = i + 1; j < SLICE_W; j++) begin
                upper_same = upper_same & same_bit[j];
            end
            gt_acc = gt_acc | (a_i[i] & ~b_i[i] & upper_same);
        end
    end

    // Pack the slice results.
    always_comb begin : slice_out
        flags_o.eq = &same_bit;
        flags_o.gt = gt_acc;
    end

    // Check: a slice cannot report equal and greater together.
    always_comb begin : slice_chk
        assert_slice_excl_R6: assert (!(flags_o.eq && flags_o.gt))
            else $error("slice reports equal and greater together");
    end

endmodule

// File: rtl/cmp_merge.sv
// Module: cmp_merge
// Joins the per-slice flags in one parallel sum-of-products level. Slice
// NUM_SLICES-1 is the most significant. Nothing is chained between slices.
// Assumes each incoming slice never raises eq and gt together.
module cmp_merge
    import cmp_pkg::*;
#(
    parameter int NUM_SLICES = 3
) (
    input  slice_flags_t [NUM_SLICES-1:0] flags_i,
    output logic                          eq_o,
    output logic                          gt_o,
    output logic                          lt_o
);

    logic [NUM_SLICES-1:0] slice_eq;
    logic [NUM_SLICES-1:0] slice_gt;
    logic [NUM_SLICES-1:0] gt_term;

    // Split the packed flags into plain vectors.
    always_comb begin : unpack_flags
        for (int k = 0; k < NUM_SLICES; k++) begin
            slice_eq[k] = flags_i[k].eq;
            slice_gt[k] = flags_i[k].gt;
        end
    end

    // One product term per slice: slice k wins when every more significant slice matches.
    generate
        for (genvar k = 0; k < NUM_SLICES; k++) begin : g_term
            if (k == NUM_SLICES - 1) begin : g_top
                always_comb begin : top_term
                    gt_term[k] = slice_gt[k];
                end
            end else begin : g_low
                always_comb begin : low_term
                    gt_term[k] = slice_gt[k] & (&slice_eq[NUM_SLICES-1:k+1]);
                end
            end
        end
    endgenerate

    // OR the terms and derive less-than from the other two results.
    always_comb begin : merge_out
        eq_o = &slice_eq;
        gt_o = |gt_term;
        lt_o = ~(eq_o | gt_o);
    end

    // Check: the three results are mutually exclusive and cover every case.
    always_comb begin : merge_chk
        assert_onehot_R6: assert ($onehot({eq_o, gt_o, lt_o}))
            else $error("merge results are not one-hot");
    end

endmodule

// File: rtl/wide_mag_cmp.sv
// Module: wide_mag_cmp
// Unsigned magnitude comparator for two WIDTH-bit operands. It is built from
// NUM_SLICES slices of SLICE_W bits whose flags are merged in parallel.
// Assumes unsigned operands with known values. It has no clock and no state.
module wide_mag_cmp
    import cmp_pkg::*;
#(
    parameter int SLICE_W    = 8,
    parameter int NUM_SLICES = 3,
    parameter int WIDTH      = SLICE_W * NUM_SLICES
) (
    input  logic [WIDTH-1:0] opd_a_i,
    input  logic [WIDTH-1:0] opd_b_i,
    output logic             equal_o,
    output logic             greater_o,
    output logic             less_o
);

    localparam int LAST_SLICE = NUM_SLICES - 1;

    slice_flags_t [LAST_SLICE:0] slice_flags;

    // One comparator per slice, slice k covering bits [k*SLICE_W +: SLICE_W].
    generate
        for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
            cmp_slice #(
                .SLICE_W (SLICE_W)
            ) u_slice (
                .a_i     (opd_a_i[k*SLICE_W +: SLICE_W]),
                .b_i     (opd_b_i[k*SLICE_W +: SLICE_W]),
                .flags_o (slice_flags[k])
            );
        end
    endgenerate

    // Parallel merge of all slice flags.
    cmp_merge #(
        .NUM_SLICES (NUM_SLICES)
    ) u_merge (
        .flags_i (slice_flags),
        .eq_o    (equal_o),
        .gt_o    (greater_o),
        .lt_o    (less_o)
    );

    // Check: the outputs agree with a direct arithmetic comparison.
    always_comb begin : top_chk
        assert_eq_R1: assert (equal_o == (opd_a_i == opd_b_i))
            else $error("equal output disagrees with operands");
        assert_gt_R8: assert (greater_o == (opd_a_i > opd_b_i))
            else $error("greater output disagrees with operands");
        assert_lt_R5: assert (less_o == (opd_a_i < opd_b_i))
            else $error("less output disagrees with operands");
    end

endmodule

// File: tb/wide_mag_cmp_test.sv
// Bench: wide_mag_cmp_test
// Directed scenarios for the 24-bit comparator. Every scenario task checks its
// own results against an arithmetic comparison computed in the bench.
module wide_mag_cmp_test;

    localparam int  W        = 24;
    localparam time HALF_CLK = 10ns;    // 50 MHz clock
    localparam int  WD_LIMIT = 200000;

    logic         clk;
    logic         rst_n;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         eq_w;
    logic         gt_w;
    logic         lt_w;

    int checks;
    int failures;
    bit done;

    wide_mag_cmp uut (
        .opd_a_i   (a),
        .opd_b_i   (b),
        .equal_o   (eq_w),
        .greater_o (gt_w),
        .less_o    (lt_w)
    );

    // Free-running clock that paces the stimulus.
    initial begin
        clk = 1'b0;
        forever #(HALF_CLK) clk = ~clk;
    end

    // Record one check result.
    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s a=%h b=%h actual{eq,gt,lt}=%b expected=%b", tag, a, b, act, exp);
        end
    endtask

    // Apply a pair away from the clock edge, let it settle, then check it against arithmetic.
    task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input string tag);
        logic [2:0] exp;
        @(negedge clk);
        a = va;
        b = vb;
        #5ns;
        exp = {va == vb, va > vb, va < vb};
        check(tag, {eq_w, gt_w, lt_w}, exp);
        check("R6 onehot", {2'b00, $onehot({eq_w, gt_w, lt_w})}, 3'b001);
    endtask

    // R1: equality, including all-zero and all-one operands.
    task automatic test_equal();
        apply(24'h000000, 24'h000000, "R1 zero");
        apply(24'hFFFFFF, 24'hFFFFFF, "R1 ones");
        apply(24'h5A3C96, 24'h5A3C96, "R1 mixed");
        apply(24'h5A3C96, 24'h5A3C97, "R1 lsb differs");
    endtask

    // R2: the top byte decides, whatever the lower bytes hold.
    task automatic test_top_byte();
        apply(24'h81_0000, 24'h80_FFFF, "R2 a top larger");
        apply(24'h7F_FFFF, 24'h80_0000, "R2 b top larger");
    endtask

    // R3: with the top byte equal, the middle byte decides.
    task automatic test_mid_byte();
        apply(24'h33_41_00, 24'h33_40_FF, "R3 a mid larger");
        apply(24'h33_40_FF, 24'h33_41_00, "R3 b mid larger");
    endtask

    // R4: with the upper two bytes equal, the low byte decides.
    task automatic test_low_byte();
        apply(24'hABCD_01, 24'hABCD_00, "R4 a low larger");
        apply(24'hABCD_7F, 24'hABCD_80, "R4 b low larger");
    endtask

    // R7: unsigned treatment of bit 23.
    task automatic test_unsigned();
        apply(24'h800000, 24'h7FFFFF, "R7 msb set is large");
        apply(24'h000001, 24'hFFFFFF, "R7 small vs max");
    endtask

    // R5 and R8: random pairs, some of them sharing upper bytes.
    task automatic test_random();
        for (int n = 0; n < 300; n++) begin
            logic [W-1:0] ra;
            logic [W-1:0] rb;
            ra = W'($urandom);
            rb = W'($urandom);
            if (n % 3 == 1) rb[23:8] = ra[23:8];
            if (n % 3 == 2) rb[23:16] = ra[23:16];
            apply(ra, rb, (n % 2 == 0) ? "R8 random" : "R5 random");
        end
    endtask

    // Print the single summary line and stop.
    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    // Scenario sequence.
    initial begin
        checks   = 0;
        failures = 0;
        done     = 1'b0;
        rst_n    = 1'b0;
        a        = '0;
        b        = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", {eq_w, gt_w, lt_w}, 3'b100);
        test_equal();
        test_top_byte();
        test_mid_byte();
        test_low_byte();
        test_unsigned();
        test_random();
        done = 1'b1;
        finish_run();
    end

endmodule